// File: doc/BRIEF.md
# Single-Lane 66-Bit Block Frame Receiver

This block turns a stream of 66-bit line blocks from one lane into AXI4-Stream frames. Each block has a 2-bit sync header and 64 payload bits. A data block (header `2'b01`) carries eight frame bytes. A control block (header `2'b10`) carries a type byte in payload bits [7:0]. A separator control block closes the frame and says how many of its remaining six bytes belong to the frame. All other control blocks are discarded: idle fill, clock-compensation and types the block does not know. Descrambling, block lock, lane alignment and CRC are handled elsewhere. The input is already descrambled and aligned.

One frame beat is always held back. When a separator with a zero count arrives, that held data beat becomes the frame's last beat, so no empty beat is ever emitted. When a separator carries bytes, those bytes become a short final beat. The low tkeep bits on that beat mark the valid bytes. Two input faults raise the one-cycle `err` output: an illegal sync header, and a separator count above six.

Top module: `blk66_frame_rx`

## Requirements
- R1: A block with `blk_valid`=1 and header `2'b01` yields one beat with tdata equal to the 64-bit payload (frame byte k = payload bits [8k+7:8k]), tkeep=8'hFF and tlast=0, unless a zero-count separator later closes the frame on it (R3).
- R2: A separator (header `2'b10`, payload[7:0]=8'h1E) with count n = payload[15:8] in 1..6 yields a final beat with tlast=1. On that beat, tkeep has its low n bits set, byte k of tdata is payload byte k+2 for k<n, and every other byte of tdata is zero.
- R3: A separator with count 0 marks the held data beat as last (tkeep=8'hFF, tlast=1). This beat appears one cycle after the separator, and no empty beat is produced.
- R4: Control blocks with any type other than 8'h1E produce no beat and leave a partially received frame intact. This covers idle (8'h78, payload[15:8]=8'h00), clock compensation (8'h78, payload[15:8]=8'h55) and unknown types.
- R5: A valid block with header `2'b00` or `2'b11` is discarded, and `err` is high for exactly the following cycle.
- R6: A separator count above 6 pulses `err` for one cycle, and the count is treated as 6.
- R7: A non-last beat is output in the cycle after the next beat-producing block (data, or separator with a nonzero count) is accepted. A final beat built from separator bytes is output in the cycle after the one following the separator.
- R8: Cycles with `blk_valid`=0 are ignored, whatever the header and payload. A zero-count separator with no held data beat produces nothing.
- R9: While `rst_n` is low, and after reset, `m_tvalid` and `err` are 0. A frame in progress at reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | Block strobe |
| blk_hdr | input | 2 | Sync header of the block |
| blk_payload | input | 64 | Block payload, byte 0 in bits [7:0] |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | 64 | Beat data |
| m_tkeep | output | 8 | Valid-byte mask, low bits first |
| m_tlast | output | 1 | Last beat of frame |
| err | output | 1 | One-cycle error pulse |

## Verification
A vector table covers several frame shapes:
- Frames that end on a separator with bytes, and frames that end with a zero count. These tell the short-final-beat path apart from the held-beat-close path.
- Separator-only frames, which show the hold register carries both kinds of beat.
- Idle, clock-compensation and unknown blocks placed inside frames, which show that dropped blocks leave the held beat intact.
- Bad headers, an oversized count and strobe-low cycles, which separate an error pulse from an output beat.

A randomized run sends frames of random length and final count with random filler between blocks. It compares every beat against a model kept in the bench. A reset issued mid-frame confirms that the held beat is discarded.

// File: rtl/blk66_frame_rx.sv
module blk66_frame_rx #(
  parameter int          DATA_W   = 64,
  parameter logic [7:0]  SEP_TYPE = 8'h1E,
  parameter int          MAX_SEP  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_valid,
  input  logic [1:0]          blk_hdr,
  input  logic [DATA_W-1:0]   blk_payload,
  output logic                m_tvalid,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic                m_tlast,
  output logic                err
);
  localparam int BYTES = DATA_W / 8;
  localparam int SEP_BYTES = BYTES - 2;

  logic [7:0] ctype, cnt_raw, cnt;
  logic is_data, is_sep, bad_hdr, cnt_over, push, close0;
  logic [DATA_W-1:0] sep_data, new_data, hold_data;
  logic [BYTES-1:0]  sep_keep, new_keep, hold_keep;
  logic hold_v, hold_last;

  assign ctype    = blk_payload[7:0];
  assign cnt_raw  = blk_payload[15:8];
  assign is_data  = blk_valid && blk_hdr == 2'b01;
  assign is_sep   = blk_valid && blk_hdr == 2'b10 && ctype == SEP_TYPE;
  assign bad_hdr  = blk_valid && (blk_hdr == 2'b00 || blk_hdr == 2'b11);
  assign cnt_over = is_sep && cnt_raw > 8'(MAX_SEP);
  assign cnt      = cnt_over ? 8'(MAX_SEP) : cnt_raw;

  for (genvar i = 0; i < BYTES; i++) begin : g_sep
    assign sep_keep[i] = 8'(i) < cnt;
    if (i < SEP_BYTES) begin : g_b
      assign sep_data[8*i +: 8] = (8'(i) < cnt) ? blk_payload[8*(i+2) +: 8] : 8'h00;
    end else begin : g_z
      assign sep_data[8*i +: 8] = 8'h00;
    end
  end

  assign push     = is_data || (is_sep && cnt != 8'd0);
  assign close0   = is_sep && cnt == 8'd0;
  assign new_data = is_data ? blk_payload : sep_data;
  assign new_keep = is_data ? {BYTES{1'b1}} : sep_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid  <= 1'b0;
      m_tdata   <= '0;
      m_tkeep   <= '0;
      m_tlast   <= 1'b0;
      err       <= 1'b0;
      hold_v    <= 1'b0;
      hold_last <= 1'b0;
      hold_data <= '0;
      hold_keep <= '0;
    end else begin
      m_tvalid <= 1'b0;
      err      <= bad_hdr || cnt_over;
      if (push) begin
        if (hold_v) begin
          m_tvalid <= 1'b1;
          m_tdata  <= hold_data;
          m_tkeep  <= hold_keep;
          m_tlast  <= hold_last;
        end
        hold_v    <= 1'b1;
        hold_last <= !is_data;
        hold_data <= new_data;
        hold_keep <= new_keep;
      end else if (hold_v && (close0 || hold_last)) begin
        m_tvalid <= 1'b1;
        m_tdata  <= hold_data;
        m_tkeep  <= hold_keep;
        m_tlast  <= 1'b1;
        hold_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk66_frame_rx_chk.sv
module blk66_frame_rx_chk #(
  parameter int          DATA_W   = 64,
  parameter logic [7:0]  SEP_TYPE = 8'h1E,
  parameter int          MAX_SEP  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                blk_valid,
  input logic [1:0]          blk_hdr,
  input logic [DATA_W-1:0]   blk_payload,
  input logic                m_tvalid,
  input logic [DATA_W/8-1:0] m_tkeep,
  input logic                m_tlast,
  input logic                err
);
  localparam int BYTES = DATA_W / 8;

  AST_BODY_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> m_tkeep == {BYTES{1'b1}}); // R1

  AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0)); // R2

  AST_SHORT_KEEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tkeep != {BYTES{1'b1}} |-> $countones(m_tkeep) <= MAX_SEP); // R6

  AST_BAD_HDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && (blk_hdr == 2'b00 || blk_hdr == 2'b11) |=> err); // R5

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(blk_valid && (blk_hdr == 2'b00 || blk_hdr == 2'b11 ||
      (blk_hdr == 2'b10 && blk_payload[7:0] == SEP_TYPE && blk_payload[15:8] > 8'(MAX_SEP))))); // R5

  AST_BODY_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> $past(blk_valid)); // R7
endmodule

bind blk66_frame_rx blk66_frame_rx_chk #(.DATA_W(DATA_W), .SEP_TYPE(SEP_TYPE), .MAX_SEP(MAX_SEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_hdr(blk_hdr),
  .blk_payload(blk_payload), .m_tvalid(m_tvalid), .m_tkeep(m_tkeep),
  .m_tlast(m_tlast), .err(err));

// File: tb/blk66_frame_rx_tb_top.sv
module blk66_frame_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_valid = 1'b0;
  logic [1:0] blk_hdr = 2'b00;
  logic [63:0] blk_payload = '0;
  logic m_tvalid, m_tlast, err;
  logic [63:0] m_tdata;
  logic [7:0] m_tkeep;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blk66_frame_rx dut_i (.clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_hdr(blk_hdr),
    .blk_payload(blk_payload), .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .err(err));

  // {req, valid, hdr, payload, exp_tvalid, exp_tlast, exp_tkeep, exp_tdata, exp_err}
  localparam int NV = 21;
  localparam logic [145:0] VEC [NV] = '{
    {4'd1, 1'b1, 2'b01, 64'h0706050403020100, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R1 held
    {4'd1, 1'b1, 2'b01, 64'h0F0E0D0C0B0A0908, 1'b1, 1'b0, 8'hFF, 64'h0706050403020100, 1'b0}, // R1
    {4'd4, 1'b1, 2'b10, 64'h0000000000000078, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R4 idle
    {4'd4, 1'b1, 2'b10, 64'h0000000000005578, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R4 clock comp
    {4'd7, 1'b1, 2'b10, 64'h665544332211031E, 1'b1, 1'b0, 8'hFF, 64'h0F0E0D0C0B0A0908, 1'b0}, // R7
    {4'd2, 1'b1, 2'b10, 64'h0000000000000078, 1'b1, 1'b1, 8'h07, 64'h0000000000332211, 1'b0}, // R2
    {4'd1, 1'b1, 2'b01, 64'h1111111111111111, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R1
    {4'd3, 1'b1, 2'b10, 64'h000000000000001E, 1'b1, 1'b1, 8'hFF, 64'h1111111111111111, 1'b0}, // R3
    {4'd8, 1'b1, 2'b10, 64'h000000000000001E, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R8 empty sep
    {4'd5, 1'b1, 2'b00, 64'hDEADBEEFDEADBEEF, 1'b0, 1'b0, 8'h00, 64'h0, 1'b1},                // R5
    {4'd5, 1'b1, 2'b11, 64'h000000000000061E, 1'b0, 1'b0, 8'h00, 64'h0, 1'b1},                // R5
    {4'd5, 1'b1, 2'b01, 64'h2222222222222222, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R5 pulse ends
    {4'd6, 1'b1, 2'b10, 64'hFFEEDDCCBBAA091E, 1'b1, 1'b0, 8'hFF, 64'h2222222222222222, 1'b1}, // R6
    {4'd6, 1'b0, 2'b00, 64'h0,                1'b1, 1'b1, 8'h3F, 64'h0000FFEEDDCCBBAA, 1'b0}, // R6 clamp
    {4'd2, 1'b1, 2'b10, 64'h060504030201061E, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R2 sep-only
    {4'd2, 1'b1, 2'b01, 64'h3333333333333333, 1'b1, 1'b1, 8'h3F, 64'h0000060504030201, 1'b0}, // R2
    {4'd8, 1'b0, 2'b01, 64'h5555555555555555, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R8 strobe low
    {4'd4, 1'b1, 2'b10, 64'h000000000000004B, 1'b0, 1'b0, 8'h00, 64'h0, 1'b0},                // R4 unknown
    {4'd8, 1'b1, 2'b10, 64'h0000000000009A011E >> 0, 1'b1, 1'b0, 8'hFF, 64'h3333333333333333, 1'b0}, // R8 hold kept
    {4'd2, 1'b1, 2'b01, 64'h4444444444444444, 1'b1, 1'b1, 8'h01, 64'h000000000000009A, 1'b0}, // R2 count 1
    {4'd3, 1'b1, 2'b10, 64'h000000000000001E, 1'b1, 1'b1, 8'hFF, 64'h4444444444444444, 1'b0}  // R3
  };

  task automatic drive(input logic v, input logic [1:0] h, input logic [63:0] p);
    @(negedge clk);
    blk_valid = v; blk_hdr = h; blk_payload = p;
  endtask

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  logic [63:0] exp_d [512];
  logic [7:0]  exp_k [512];
  logic        exp_l [512];
  int wr = 0, rd = 0;
  bit mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en && m_tvalid) begin
      n_chk++;
      if (rd >= wr || m_tdata !== exp_d[rd] || m_tkeep !== exp_k[rd] || m_tlast !== exp_l[rd]) begin
        n_fail++;
        $display("FAIL R1/R2/R3/R4 random beat %0d: got d=%h k=%h l=%b exp d=%h k=%h l=%b",
          rd, m_tdata, m_tkeep, m_tlast, exp_d[rd], exp_k[rd], exp_l[rd]);
      end
      rd++;
    end
    if (mon_en && err) begin
      n_chk++; n_fail++;
      $display("FAIL R5 random: got err=1 exp err=0");
    end
  end

  task automatic filler();
    int n = $urandom_range(0, 2);
    for (int i = 0; i < n; i++) begin
      case ($urandom_range(0, 2))
        0: drive(1'b1, 2'b10, 64'h78);
        1: drive(1'b1, 2'b10, 64'h5578);
        default: drive(1'b0, 2'b01, {$urandom, $urandom});
      endcase
    end
  endtask

  initial begin
    logic [145:0] v;
    logic [63:0] p, sd;
    int len, c;
    repeat (3) @(posedge clk);
    #1;
    chk(m_tvalid === 1'b0 && err === 1'b0, "R9", $sformatf("in reset got v=%b e=%b exp 0 0", m_tvalid, err));
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      drive(v[141], v[140:139], v[138:75]);
      @(posedge clk); #1;
      if (v[74])
        chk(m_tvalid === 1'b1 && m_tlast === v[73] && m_tkeep === v[72:65] && m_tdata === v[64:1] && err === v[0],
          $sformatf("R%0d", v[145:142]),
          $sformatf("vec %0d got v=%b l=%b k=%h d=%h e=%b exp v=1 l=%b k=%h d=%h e=%b", i,
            m_tvalid, m_tlast, m_tkeep, m_tdata, err, v[73], v[72:65], v[64:1], v[0]));
      else
        chk(m_tvalid === 1'b0 && err === v[0], $sformatf("R%0d", v[145:142]),
          $sformatf("vec %0d got v=%b e=%b exp v=0 e=%b", i, m_tvalid, err, v[0]));
    end

    // R9: reset mid-frame drops the held beat
    drive(1'b1, 2'b01, 64'h7777777777777777);
    drive(1'b0, 2'b00, 64'h0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk(m_tvalid === 1'b0 && err === 1'b0, "R9", $sformatf("mid reset got v=%b e=%b exp 0 0", m_tvalid, err));
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 2'b10, 64'h1E);
    @(posedge clk); #1;
    chk(m_tvalid === 1'b0, "R9", $sformatf("after reset close got v=%b exp 0", m_tvalid));
    drive(1'b1, 2'b10, 64'h78);
    @(posedge clk); #1;
    chk(m_tvalid === 1'b0, "R9", $sformatf("after reset idle got v=%b exp 0", m_tvalid));

    // Random frames with filler (R1 R2 R3 R4)
    mon_en = 1'b1;
    for (int f = 0; f < 60; f++) begin
      len = $urandom_range(0, 4);
      c = $urandom_range(0, 6);
      if (len == 0 && c == 0) c = 1;
      for (int b = 0; b < len; b++) begin
        p = {$urandom, $urandom};
        exp_d[wr] = p; exp_k[wr] = 8'hFF; exp_l[wr] = 1'b0; wr++;
        drive(1'b1, 2'b01, p);
        filler();
      end
      p = {$urandom, $urandom};
      p[15:0] = {8'(c), 8'h1E};
      if (c == 0) exp_l[wr-1] = 1'b1;
      else begin
        sd = '0;
        for (int k = 0; k < c; k++) sd[8*k +: 8] = p[8*(k+2) +: 8];
        exp_d[wr] = sd; exp_k[wr] = 8'((1 << c) - 1); exp_l[wr] = 1'b1; wr++;
      end
      drive(1'b1, 2'b10, p);
      filler();
    end
    drive(1'b1, 2'b10, 64'h78);
    drive(1'b0, 2'b00, 64'h0);
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    chk(rd == wr, "R3", $sformatf("random beat count got %0d exp %0d", rd, wr));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule